// File: doc/BRIEF.md
# Vector store precise-trap issue controller

This block sits between a vector store unit and a memory write port. It collects the elements of one vector store. Each element has an index, an address, data and two flags that an earlier page-table lookup has resolved: one marks a translation fault, the other marks a target in idempotent memory. The block sends the element writes to memory, out of element order where that is allowed, and still keeps traps precise.

In the unordered modes, each cycle the block picks the eligible element with the lowest address. A write to a non-idempotent target waits until every lower-indexed element is known to be fault-free. An idempotent write may go out early, even above an element that later faults. In indexed-ordered mode, writes leave strictly by rising index. When a fault is found, the block issues only the lower-indexed writes still pending and waits until every outstanding write has completed. It then pulses a trap with the faulting index as the restart point. If no element faults, it pulses done once every write has completed.

Top module: `vst_trap_ctrl`

## Requirements
- R1: After reset `st_ready` is 1 and `mw_valid`, `trap_pulse` and `done_pulse` are 0. No write is offered while `st_ready` is 1.
- R2: In modes 0 (unit-stride), 1 (strided) and 2 (indexed-unordered), the write offered is the eligible element with the lowest address. Equal addresses go in lower-index order.
- R3: In mode 3 (indexed-ordered), writes are issued in strictly increasing element index.
- R4: When every element below `st_count` has completed and none faulted, `done_pulse` is 1 for one cycle and `st_ready` returns to 1.
- R5: On a fault, `trap_pulse` is 1 for exactly one cycle. `trap_vstart` equals the lowest faulting element index.
- R6: `trap_pulse` rises only after every element below the faulting index has received its completion (`mc_valid` with `mc_idx`), and after no issued write is outstanding.
- R7: A faulting element is never written. A non-idempotent element at or above the faulting index is never written.
- R8: An idempotent element may be written before lower-indexed elements have arrived, even when a lower element later faults.
- R9: A non-idempotent element is not written until every lower-indexed element has arrived without a fault.
- R10: While a store is in progress, `st_ready` is 0 and `st_start` is ignored: the element count and mode stay those of the accepted store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_start | input | 1 | Begin a store (taken only when `st_ready` is 1) |
| st_mode | input | 2 | 0 unit-stride, 1 strided, 2 indexed-unordered, 3 indexed-ordered |
| st_count | input | CNT_W | Number of elements in the store |
| st_ready | output | 1 | Idle and able to accept a store |
| el_valid | input | 1 | Element result present this cycle |
| el_idx | input | IDX_W | Element index |
| el_addr | input | ADDR_W | Translated element address |
| el_data | input | DATA_W | Element data |
| el_fault | input | 1 | Translation fault for this element |
| el_idem | input | 1 | Target is idempotent memory |
| mw_valid | output | 1 | Write offered to memory |
| mw_ready | input | 1 | Memory accepts the offered write |
| mw_idx | output | IDX_W | Element index of offered write |
| mw_addr | output | ADDR_W | Write address |
| mw_data | output | DATA_W | Write data |
| mc_valid | input | 1 | Write completion beat |
| mc_idx | input | IDX_W | Index of the completed write |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_vstart | output | IDX_W | Restart index (faulting element) |
| done_pulse | output | 1 | One-cycle fault-free completion |

## Verification
An element that is loaded at one rising edge can show on the write port during the next cycle. The write is accepted at the edge where `mw_ready` is high. A completion beat driven in one cycle takes effect at the following edge, and a trap or done pulse appears one edge after that. The bench drives stimulus just after rising edges and samples every port and handshake on the falling edge. This lets it see each one-cycle pulse exactly once. For the hold-back cases it allows several idle cycles before checking that no write occurred, and only then supplies the missing lower elements or releases the stalled completions.

// File: rtl/vst_trap_pkg.sv
package vst_trap_pkg;

   typedef enum logic [1:0] {
      VM_UNIT      = 2'd0,
      VM_STRIDE    = 2'd1,
      VM_IDX_UNORD = 2'd2,
      VM_IDX_ORD   = 2'd3
   } vmode_e;

   typedef enum logic {
      CS_IDLE = 1'b0,
      CS_RUN  = 1'b1
   } ctl_state_e;

endpackage

// File: rtl/vst_elem_table.sv
module vst_elem_table #(
   parameter int N  = 8,
   parameter int AW = 32,
   parameter int DW = 64,
   parameter int IW = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic [N-1:0]         alloc,
   input  logic                 ld_en,
   input  logic [IW-1:0]        ld_idx,
   input  logic [AW-1:0]        ld_addr,
   input  logic [DW-1:0]        ld_data,
   input  logic                 ld_fault,
   input  logic                 ld_idem,
   input  logic                 iss_en,
   input  logic [IW-1:0]        iss_idx,
   input  logic                 cpl_en,
   input  logic [IW-1:0]        cpl_idx,
   output logic [N-1:0]         e_valid,
   output logic [N-1:0]         e_xlat,
   output logic [N-1:0]         e_fault,
   output logic [N-1:0]         e_idem,
   output logic [N-1:0]         e_issued,
   output logic [N-1:0]         e_done,
   output logic [N-1:0][AW-1:0] e_addr,
   output logic [N-1:0][DW-1:0] e_data
);

   for (genvar i = 0; i < N; i++) begin : g_ent
      logic          v_q, x_q, f_q, id_q, is_q, d_q;
      logic [AW-1:0] a_q;
      logic [DW-1:0] dt_q;
      logic          hit_ld;

      assign hit_ld = ld_en && (ld_idx == IW'(i)) && v_q && !x_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            x_q  <= 1'b0;
            f_q  <= 1'b0;
            id_q <= 1'b0;
            is_q <= 1'b0;
            d_q  <= 1'b0;
         end else if (clr) begin
            v_q  <= alloc[i];
            x_q  <= 1'b0;
            f_q  <= 1'b0;
            id_q <= 1'b0;
            is_q <= 1'b0;
            d_q  <= 1'b0;
         end else begin
            if (hit_ld) begin
               x_q  <= 1'b1;
               f_q  <= ld_fault;
               id_q <= ld_idem;
            end
            if (iss_en && (iss_idx == IW'(i))) is_q <= 1'b1;
            if (cpl_en && (cpl_idx == IW'(i)) && is_q) d_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_ld) begin
            a_q  <= ld_addr;
            dt_q <= ld_data;
         end
      end

      assign e_valid[i]  = v_q;
      assign e_xlat[i]   = x_q;
      assign e_fault[i]  = f_q;
      assign e_idem[i]   = id_q;
      assign e_issued[i] = is_q;
      assign e_done[i]   = d_q;
      assign e_addr[i]   = a_q;
      assign e_data[i]   = dt_q;
   end

endmodule

// File: rtl/vst_fault_scan.sv
module vst_fault_scan #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  e_valid,
   input  logic [N-1:0]  e_xlat,
   input  logic [N-1:0]  e_fault,
   input  logic [N-1:0]  e_issued,
   input  logic [N-1:0]  e_done,
   output logic [N-1:0]  safe_below,
   output logic          ff_known,
   output logic [IW-1:0] ff_idx,
   output logic          ff_lower_done,
   output logic          all_done,
   output logic          in_flight
);

   logic acc_ok, acc_done;

   always_comb begin
      acc_ok        = 1'b1;
      acc_done      = 1'b1;
      ff_known      = 1'b0;
      ff_idx        = '0;
      ff_lower_done = 1'b0;
      for (int i = 0; i < N; i++) begin
         safe_below[i] = acc_ok;
         if (!ff_known && acc_ok && e_valid[i] && e_xlat[i] && e_fault[i]) begin
            ff_known      = 1'b1;
            ff_idx        = IW'(i);
            ff_lower_done = acc_done;
         end
         acc_ok   = acc_ok & (!e_valid[i] | (e_xlat[i] & !e_fault[i]));
         acc_done = acc_done & (!e_valid[i] | e_done[i]);
      end
      all_done  = acc_done;
      in_flight = |(e_issued & ~e_done);
   end

endmodule

// File: rtl/vst_issue_pick.sv
module vst_issue_pick #(
   parameter int N       = 8,
   parameter int AW      = 32,
   parameter int IW      = 3,
   parameter bit BY_ADDR = 1'b1
) (
   input  logic [N-1:0]         e_valid,
   input  logic [N-1:0]         e_xlat,
   input  logic [N-1:0]         e_fault,
   input  logic [N-1:0]         e_idem,
   input  logic [N-1:0]         e_issued,
   input  logic [N-1:0]         safe_below,
   input  logic [N-1:0][AW-1:0] e_addr,
   input  logic                 ordered,
   input  logic                 ff_known,
   input  logic [IW-1:0]        ff_idx,
   output logic                 pick_vld,
   output logic [IW-1:0]        pick_idx
);

   logic [N-1:0] elig;
   logic         lo_all_iss;

   always_comb begin
      lo_all_iss = 1'b1;
      for (int i = 0; i < N; i++) begin
         elig[i] = e_valid[i] && e_xlat[i] && !e_fault[i] && !e_issued[i]
                   && (e_idem[i] || safe_below[i])
                   && (!ff_known || (IW'(i) < ff_idx));
         if (ordered) elig[i] = elig[i] && lo_all_iss;
         lo_all_iss = lo_all_iss && (!e_valid[i] || e_issued[i]);
      end
   end

   if (BY_ADDR) begin : g_by_addr
      logic [AW-1:0] best_a;
      always_comb begin
         pick_vld = 1'b0;
         pick_idx = '0;
         best_a   = '0;
         for (int i = 0; i < N; i++) begin
            if (elig[i] && (!pick_vld || (e_addr[i] < best_a))) begin
               pick_vld = 1'b1;
               pick_idx = IW'(i);
               best_a   = e_addr[i];
            end
         end
      end
   end else begin : g_by_idx
      always_comb begin
         pick_vld = 1'b0;
         pick_idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
               pick_vld = 1'b1;
               pick_idx = IW'(i);
            end
         end
      end
   end

endmodule

// File: rtl/vst_trap_ctrl.sv
module vst_trap_ctrl #(
   parameter int NUM_EL       = 8,
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 64,
   parameter bit PICK_BY_ADDR = 1'b1,
   localparam int IDX_W       = $clog2(NUM_EL),
   localparam int CNT_W       = $clog2(NUM_EL + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_start,
   input  logic [1:0]        st_mode,
   input  logic [CNT_W-1:0]  st_count,
   output logic              st_ready,
   input  logic              el_valid,
   input  logic [IDX_W-1:0]  el_idx,
   input  logic [ADDR_W-1:0] el_addr,
   input  logic [DATA_W-1:0] el_data,
   input  logic              el_fault,
   input  logic              el_idem,
   output logic              mw_valid,
   input  logic              mw_ready,
   output logic [IDX_W-1:0]  mw_idx,
   output logic [ADDR_W-1:0] mw_addr,
   output logic [DATA_W-1:0] mw_data,
   input  logic              mc_valid,
   input  logic [IDX_W-1:0]  mc_idx,
   output logic              trap_pulse,
   output logic [IDX_W-1:0]  trap_vstart,
   output logic              done_pulse
);
   import vst_trap_pkg::*;

   if (NUM_EL < 2 || NUM_EL > 64) begin : g_bad_num
      $error("vst_trap_ctrl: NUM_EL must be within 2..64");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("vst_trap_ctrl: ADDR_W and DATA_W must be positive");
   end

   ctl_state_e state_q;
   vmode_e     mode_q;

   logic [NUM_EL-1:0]             alloc;
   logic [NUM_EL-1:0]             e_valid, e_xlat, e_fault, e_idem, e_issued, e_done;
   logic [NUM_EL-1:0][ADDR_W-1:0] e_addr;
   logic [NUM_EL-1:0][DATA_W-1:0] e_data;
   logic [NUM_EL-1:0]             safe_below;
   logic                          ff_known, ff_lower_done, all_done, in_flight;
   logic [IDX_W-1:0]              ff_idx;
   logic                          pick_vld;
   logic [IDX_W-1:0]              pick_idx;
   logic                          running, clr, ld_en, iss_en, trap_cond, done_cond;

   assign running  = (state_q == CS_RUN);
   assign st_ready = (state_q == CS_IDLE);
   assign clr      = st_start && st_ready;
   assign ld_en    = el_valid && running;

   for (genvar i = 0; i < NUM_EL; i++) begin : g_alloc
      assign alloc[i] = (CNT_W'(i) < st_count);
   end

   vst_elem_table #(.N(NUM_EL), .AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .alloc    (alloc),
      .ld_en    (ld_en),
      .ld_idx   (el_idx),
      .ld_addr  (el_addr),
      .ld_data  (el_data),
      .ld_fault (el_fault),
      .ld_idem  (el_idem),
      .iss_en   (iss_en),
      .iss_idx  (pick_idx),
      .cpl_en   (mc_valid),
      .cpl_idx  (mc_idx),
      .e_valid  (e_valid),
      .e_xlat   (e_xlat),
      .e_fault  (e_fault),
      .e_idem   (e_idem),
      .e_issued (e_issued),
      .e_done   (e_done),
      .e_addr   (e_addr),
      .e_data   (e_data)
   );

   vst_fault_scan #(.N(NUM_EL), .IW(IDX_W)) u_scan (
      .e_valid       (e_valid),
      .e_xlat        (e_xlat),
      .e_fault       (e_fault),
      .e_issued      (e_issued),
      .e_done        (e_done),
      .safe_below    (safe_below),
      .ff_known      (ff_known),
      .ff_idx        (ff_idx),
      .ff_lower_done (ff_lower_done),
      .all_done      (all_done),
      .in_flight     (in_flight)
   );

   vst_issue_pick #(.N(NUM_EL), .AW(ADDR_W), .IW(IDX_W), .BY_ADDR(PICK_BY_ADDR)) u_pick (
      .e_valid    (e_valid),
      .e_xlat     (e_xlat),
      .e_fault    (e_fault),
      .e_idem     (e_idem),
      .e_issued   (e_issued),
      .safe_below (safe_below),
      .e_addr     (e_addr),
      .ordered    (mode_q == VM_IDX_ORD),
      .ff_known   (ff_known),
      .ff_idx     (ff_idx),
      .pick_vld   (pick_vld),
      .pick_idx   (pick_idx)
   );

   assign mw_valid  = running && pick_vld;
   assign mw_idx    = pick_idx;
   assign mw_addr   = e_addr[pick_idx];
   assign mw_data   = e_data[pick_idx];
   assign iss_en    = mw_valid && mw_ready;
   assign trap_cond = running && ff_known && ff_lower_done && !in_flight;
   assign done_cond = running && !ff_known && all_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= CS_IDLE;
         mode_q      <= VM_UNIT;
         trap_pulse  <= 1'b0;
         trap_vstart <= '0;
         done_pulse  <= 1'b0;
      end else begin
         trap_pulse <= 1'b0;
         done_pulse <= 1'b0;
         case (state_q)
            CS_IDLE: begin
               if (st_start) begin
                  state_q <= CS_RUN;
                  mode_q  <= vmode_e'(st_mode);
               end
            end
            CS_RUN: begin
               if (trap_cond) begin
                  trap_pulse  <= 1'b1;
                  trap_vstart <= ff_idx;
                  state_q     <= CS_IDLE;
               end else if (done_cond) begin
                  done_pulse <= 1'b1;
                  state_q    <= CS_IDLE;
               end
            end
            default: state_q <= CS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/vst_trap_ctrl_chk.sv
module vst_trap_ctrl_chk #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_ready,
   input logic          mw_valid,
   input logic          mw_ready,
   input logic [IW-1:0] mw_idx,
   input logic          trap_pulse,
   input logic [IW-1:0] trap_vstart,
   input logic          done_pulse,
   input logic [1:0]    mode,
   input logic [N-1:0]  e_valid,
   input logic [N-1:0]  e_xlat,
   input logic [N-1:0]  e_fault,
   input logic [N-1:0]  e_idem,
   input logic [N-1:0]  e_done
);
   import vst_trap_pkg::*;

   logic          fire, sel_safe, lo_done_vs, seen_q;
   logic [IW-1:0] last_q;

   assign fire = mw_valid && mw_ready;

   always_comb begin
      sel_safe   = 1'b1;
      lo_done_vs = 1'b1;
      for (int j = 0; j < N; j++) begin
         if (IW'(j) < mw_idx && e_valid[j] && !(e_xlat[j] && !e_fault[j])) sel_safe = 1'b0;
         if (IW'(j) < trap_vstart && e_valid[j] && !e_done[j]) lo_done_vs = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         last_q <= '0;
      end else if (st_ready) begin
         seen_q <= 1'b0;
      end else if (fire) begin
         seen_q <= 1'b1;
         last_q <= mw_idx;
      end
   end

   // R1
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_ready |-> !mw_valid);

   // R4 R5
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({trap_pulse, done_pulse}));

   // R5
   trap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |=> !trap_pulse);

   // R3
   ord_increase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == VM_IDX_ORD && seen_q) |-> (mw_idx > last_q));

   // R9
   nonidem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !e_idem[mw_idx]) |-> sel_safe);

   // R6
   trap_after_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_pulse |-> lo_done_vs);

   // R7
   no_fault_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid |-> !e_fault[mw_idx]);

endmodule

bind vst_trap_ctrl vst_trap_ctrl_chk #(.N(NUM_EL), .IW(IDX_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .st_ready    (st_ready),
   .mw_valid    (mw_valid),
   .mw_ready    (mw_ready),
   .mw_idx      (mw_idx),
   .trap_pulse  (trap_pulse),
   .trap_vstart (trap_vstart),
   .done_pulse  (done_pulse),
   .mode        (mode_q),
   .e_valid     (e_valid),
   .e_xlat      (e_xlat),
   .e_fault     (e_fault),
   .e_idem      (e_idem),
   .e_done      (e_done)
);

// File: tb/vst_trap_ctrl_tb.sv
`timescale 1ns/1ps
module vst_trap_ctrl_tb_top;

   localparam int NE = 8;
   localparam int IW = $clog2(NE);
   localparam int CW = $clog2(NE + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_start = 1'b0;
   logic [1:0]    st_mode = 2'd0;
   logic [CW-1:0] st_count = '0;
   logic          st_ready;
   logic          el_valid = 1'b0;
   logic [IW-1:0] el_idx = '0;
   logic [31:0]   el_addr = '0;
   logic [63:0]   el_data = '0;
   logic          el_fault = 1'b0;
   logic          el_idem = 1'b0;
   logic          mw_valid;
   logic          mw_ready = 1'b1;
   logic [IW-1:0] mw_idx;
   logic [31:0]   mw_addr;
   logic [63:0]   mw_data;
   logic          mc_valid = 1'b0;
   logic [IW-1:0] mc_idx = '0;
   logic          trap_pulse;
   logic [IW-1:0] trap_vstart;
   logic          done_pulse;

   vst_trap_ctrl #(.NUM_EL(NE), .ADDR_W(32), .DATA_W(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_start(st_start), .st_mode(st_mode),
      .st_count(st_count), .st_ready(st_ready), .el_valid(el_valid),
      .el_idx(el_idx), .el_addr(el_addr), .el_data(el_data),
      .el_fault(el_fault), .el_idem(el_idem), .mw_valid(mw_valid),
      .mw_ready(mw_ready), .mw_idx(mw_idx), .mw_addr(mw_addr),
      .mw_data(mw_data), .mc_valid(mc_valid), .mc_idx(mc_idx),
      .trap_pulse(trap_pulse), .trap_vstart(trap_vstart),
      .done_pulse(done_pulse)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int nchk = 0, nfail = 0;
   int nwr = 0, ntrap = 0, ndone = 0, npend = 0;
   int trap_v = -1, trap_cyc = 0;
   int wr_idx[16];
   int pend[16];
   int cpl_cyc[NE];
   bit stall = 1'b0;

   // memory model and output monitor, all on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (!stall && npend > 0) begin
            mc_valid = 1'b1;
            mc_idx   = IW'(pend[0]);
            cpl_cyc[pend[0]] = cyc;
            for (int k = 0; k < 15; k++) pend[k] = pend[k+1];
            npend--;
         end else begin
            mc_valid = 1'b0;
         end
         if (mw_valid && mw_ready && nwr < 16) begin
            wr_idx[nwr] = int'(mw_idx);
            nwr++;
            pend[npend] = int'(mw_idx);
            npend++;
         end
         if (trap_pulse) begin
            ntrap++;
            trap_v   = int'(trap_vstart);
            trap_cyc = cyc;
         end
         if (done_pulse) ndone++;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      nwr = 0; ntrap = 0; ndone = 0; trap_v = -1; trap_cyc = 0;
   endtask

   task automatic begin_store(input int mode, input int count);
      clear_logs();
      st_start = 1'b1;
      st_mode  = 2'(mode);
      st_count = CW'(count);
      tick();
      st_start = 1'b0;
   endtask

   task automatic load(input int idx, input int addr, input bit flt, input bit idem);
      el_valid = 1'b1;
      el_idx   = IW'(idx);
      el_addr  = 32'(addr);
      el_data  = 64'(addr) ^ 64'hA5A5_0000;
      el_fault = flt;
      el_idem  = idem;
      tick();
      el_valid = 1'b0;
   endtask

   task automatic wait_end(input int limit);
      for (int k = 0; k < limit && ntrap + ndone == 0; k++) tick();
      repeat (2) tick();
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk_eq("R1", "ready after reset", int'(st_ready), 1);
      chk_eq("R1", "mw_valid after reset", int'(mw_valid), 0);
      chk_eq("R1", "trap after reset", int'(trap_pulse), 0);
      chk_eq("R1", "done after reset", int'(done_pulse), 0);
      tick();
   endtask

   task automatic t_addr_order();
      mw_ready = 1'b0;
      begin_store(2, 4);
      load(0, 40, 0, 0); load(1, 10, 0, 0); load(2, 30, 0, 0); load(3, 10, 0, 0);
      mw_ready = 1'b1;
      wait_end(60);
      chk_eq("R2", "write count", nwr, 4);
      chk_eq("R2", "1st write idx", wr_idx[0], 1);
      chk_eq("R2", "2nd write idx (tie)", wr_idx[1], 3);
      chk_eq("R2", "3rd write idx", wr_idx[2], 2);
      chk_eq("R2", "4th write idx", wr_idx[3], 0);
      chk_eq("R4", "done count", ndone, 1);
      chk_eq("R4", "trap count", ntrap, 0);
      chk_eq("R4", "ready after done", int'(st_ready), 1);
   endtask

   task automatic t_ordered();
      mw_ready = 1'b0;
      begin_store(3, 4);
      load(0, 40, 0, 1); load(1, 30, 0, 0); load(2, 20, 0, 1); load(3, 10, 0, 0);
      mw_ready = 1'b1;
      wait_end(60);
      chk_eq("R3", "write count", nwr, 4);
      for (int k = 0; k < 4; k++) chk_eq("R3", "ordered write idx", wr_idx[k], k);
      chk_eq("R4", "ordered done", ndone, 1);
   endtask

   task automatic t_fault_basic();
      begin_store(0, 4);
      load(0, 100, 0, 0); load(1, 104, 0, 0); load(2, 108, 1, 0); load(3, 112, 0, 0);
      wait_end(60);
      chk_eq("R5", "trap count", ntrap, 1);
      chk_eq("R5", "trap vstart", trap_v, 2);
      chk_eq("R7", "writes before fault only", nwr, 2);
      chk_eq("R7", "no done on fault", ndone, 0);
   endtask

   task automatic t_idem_early();
      begin_store(1, 4);
      load(3, 200, 0, 1);
      repeat (3) tick();
      chk_eq("R8", "idempotent early write count", nwr, 1);
      chk_eq("R8", "idempotent early write idx", wr_idx[0], 3);
      load(2, 208, 0, 0); load(1, 204, 1, 0); load(0, 196, 0, 0);
      wait_end(60);
      chk_eq("R5", "trap vstart", trap_v, 1);
      chk_eq("R7", "non-idem above fault not written", nwr, 2);
      chk_eq("R7", "second write idx", wr_idx[1], 0);
   endtask

   task automatic t_hold_nonidem();
      begin_store(2, 3);
      load(2, 50, 0, 0);
      repeat (4) tick();
      chk_eq("R9", "held with lower missing", nwr, 0);
      load(1, 60, 0, 0);
      repeat (4) tick();
      chk_eq("R9", "held with idx0 missing", nwr, 0);
      load(0, 70, 0, 0);
      wait_end(60);
      chk_eq("R9", "all released", nwr, 3);
      chk_eq("R4", "done after release", ndone, 1);
   endtask

   task automatic t_trap_waits();
      stall = 1'b1;
      begin_store(0, 3);
      load(0, 300, 0, 0); load(1, 304, 1, 0); load(2, 308, 0, 0);
      repeat (6) tick();
      chk_eq("R6", "no trap while completion stalled", ntrap, 0);
      chk_eq("R6", "only lower element written", nwr, 1);
      stall = 1'b0;
      wait_end(60);
      chk_eq("R6", "trap after completion", ntrap, 1);
      chk_eq("R6", "trap later than completion", int'(trap_cyc > cpl_cyc[0]), 1);
      chk_eq("R5", "trap vstart", trap_v, 1);
   endtask

   task automatic t_busy_start();
      begin_store(2, 2);
      chk_eq("R10", "ready low while busy", int'(st_ready), 0);
      st_start = 1'b1; st_mode = 2'd3; st_count = CW'(4);
      tick();
      st_start = 1'b0;
      load(1, 20, 0, 0); load(0, 30, 0, 0);
      wait_end(60);
      chk_eq("R10", "done with original count", ndone, 1);
      chk_eq("R10", "write count", nwr, 2);
      chk_eq("R10", "unordered kept (addr order)", wr_idx[0], 1);
   endtask

   task automatic t_fault_first();
      begin_store(3, 2);
      load(0, 10, 1, 0); load(1, 14, 0, 1);
      wait_end(60);
      chk_eq("R5", "vstart zero", trap_v, 0);
      chk_eq("R7", "nothing written", nwr, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_addr_order();
      t_ordered();
      t_fault_basic();
      t_idem_early();
      t_hold_nonidem();
      t_trap_waits();
      t_busy_start();
      t_fault_first();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nfail, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
         $display("Result: errors=%0d of %0d checks", nfail, nchk);
         $finish;
      end
   end

endmodule